// File: doc/BRIEF.md
# Half-Rate Bit Clock and Byte Strobe Generator

This block turns a master clock into the timing signals for a bit-serial block encoder. It produces a bit clock at half the master rate and a byte strobe that marks one bit-clock period in every eight. It also produces the inverse of that strobe.

The generator stays silent after reset. The bit clock is held low until the encoder's message/checksum select input is seen high. That input is sampled on the falling master edge. The first rising master edge after such a capture starts the bit clock. From then on the bit clock toggles on every rising master edge, whatever the select input does, until the next reset.

The external reset asserts asynchronously. It is released through a short synchronizer, so the generator leaves reset on a rising master edge.

Top module: `bitclk_gen`

## Requirements
- R1: Once started, `bit_clk_o` changes state on every rising edge of `clk_i`, so its period is two master cycles.
- R2: After reset release, `bit_clk_o` stays low and does not toggle for as long as the select input has not been captured high.
- R3: `blk_sel_i` is sampled only on the falling edge of `clk_i`. A high level that covers no falling edge is ignored. A high level captured at a falling edge makes `bit_clk_o` go high at the next rising edge.
- R4: After the start, the level of `blk_sel_i` has no effect on `bit_clk_o` or on the strobes.
- R5: `byte_strb_o` is high for exactly one bit-clock period out of every eight. Counting the first bit-clock period after the start as period 1, it is high in periods 8, 16, 24 and so on. It changes only on rising transitions of `bit_clk_o`.
- R6: `byte_strb_n_o` is always the inverse of `byte_strb_o`, including during reset, when it is 1.
- R7: Driving `rst_ni` low forces `bit_clk_o` = 0, `byte_strb_o` = 0 and `byte_strb_n_o` = 1 at once, without waiting for a clock edge. The block leaves reset on the second rising edge of `clk_i` after `rst_ni` rises. A new select capture is then needed before the bit clock starts again.
- R8: The byte period count is cleared while the generator is idle. After a reset and restart, the first strobe falls again in bit-clock period 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| blk_sel_i | input | 1 | Message/checksum select; high starts a block |
| bit_clk_o | output | 1 | Half-rate bit clock, registered |
| byte_strb_o | output | 1 | Byte strobe, high one bit period in eight |
| byte_strb_n_o | output | 1 | Inverse of the byte strobe |

## Verification
The hardest case to reach from the ports is a select pulse that is high only between a falling edge and the next rising edge. Such a pulse must be missed. A second pulse, low at both rising edges but covering a falling edge, must start the clock. The stimulus places both pulses by delays measured from the rising edge, so only a design that samples on the falling edge passes both. Resets are also applied in the middle of a byte period, with the select input already held high. This shows that the count restarts from zero and that the start waits for the synchronized reset release.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;

  // Bit-clock periods in one byte strobe cycle
  localparam int unsigned BYTE_LEN_DEF = 8;

  // Reset synchronizer depth
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic {
    GEN_IDLE = 1'b0,
    GEN_RUN  = 1'b1
  } gen_state_e;

endpackage

// File: rtl/bitclk_rst_sync.sv
module bitclk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/bitclk_sel_capture.sv
module bitclk_sel_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic sel_o
);

  logic sel_q;

  // Falling-edge sample of the select input
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
    end else begin
      sel_q <= sel_i;
    end
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/bitclk_toggle.sv
module bitclk_toggle
  import bitclk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_seen_i,
  output logic run_o,
  output logic rise_o,
  output logic half_o
);

  gen_state_e state_q, state_d;
  logic       half_q, half_d;
  logic       tgl_en;

  always_comb begin
    tgl_en  = (state_q == GEN_RUN) || sel_seen_i;
    state_d = tgl_en ? GEN_RUN : state_q;
    half_d  = tgl_en ? ~half_q : half_q;
    rise_o  = tgl_en && !half_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GEN_IDLE;
      half_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      half_q  <= half_d;
    end
  end

  assign run_o  = (state_q == GEN_RUN);
  assign half_o = half_q;

endmodule

// File: rtl/bitclk_byte_strobe.sv
module bitclk_byte_strobe #(
  parameter int unsigned BYTE_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic rise_i,
  output logic strb_o,
  output logic strb_n_o
);

  localparam int unsigned CNT_W = (BYTE_LEN > 1) ? $clog2(BYTE_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_LEN - 1);

  logic [CNT_W-1:0] idx_q, idx_d;
  logic             hi_q, hi_d;
  logic             lo_q;

  always_comb begin
    idx_d = idx_q;
    hi_d  = hi_q;
    if (!run_i) begin
      idx_d = '0;
    end
    if (rise_i) begin
      if (run_i) begin
        idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + CNT_W'(1);
      end else begin
        idx_d = '0;
      end
      hi_d = (idx_d == LAST_IDX);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      hi_q  <= 1'b0;
      lo_q  <= 1'b1;
    end else begin
      idx_q <= idx_d;
      hi_q  <= hi_d;
      lo_q  <= ~hi_d;
    end
  end

  assign strb_o   = hi_q;
  assign strb_n_o = lo_q;

endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen
  import bitclk_pkg::*;
#(
  parameter int unsigned BYTE_LEN    = BYTE_LEN_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic blk_sel_i,
  output logic bit_clk_o,
  output logic byte_strb_o,
  output logic byte_strb_n_o
);

  logic rst_sync_n;
  logic sel_seen;
  logic run;
  logic rise;

  bitclk_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  bitclk_sel_capture i_sel_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .sel_i  (blk_sel_i),
    .sel_o  (sel_seen)
  );

  bitclk_toggle i_toggle (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .sel_seen_i (sel_seen),
    .run_o      (run),
    .rise_o     (rise),
    .half_o     (bit_clk_o)
  );

  bitclk_byte_strobe #(
    .BYTE_LEN (BYTE_LEN)
  ) i_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .run_i    (run),
    .rise_i   (rise),
    .strb_o   (byte_strb_o),
    .strb_n_o (byte_strb_n_o)
  );

endmodule

// File: rtl/bitclk_gen_chk.sv
module bitclk_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sel_seen,
  input logic run,
  input logic bit_clk_o,
  input logic byte_strb_o,
  input logic byte_strb_n_o
);

  // R1
  toggle_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> (bit_clk_o != $past(bit_clk_o)));

  // R2
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !sel_seen) |=> !bit_clk_o);

  // R5
  strobe_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(byte_strb_o) |-> $rose(bit_clk_o));

  // R5
  strobe_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byte_strb_o) |=> byte_strb_o ##1 !byte_strb_o);

  // R6
  strobe_inverse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_strb_n_o == !byte_strb_o);

endmodule

bind bitclk_gen bitclk_gen_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sel_seen      (sel_seen),
  .run           (run),
  .bit_clk_o     (bit_clk_o),
  .byte_strb_o   (byte_strb_o),
  .byte_strb_n_o (byte_strb_n_o)
);

// File: tb/test_bitclk_gen.sv
module test_bitclk_gen;

  localparam int CLK_PERIOD = 10;
  localparam int BYTE_LEN   = 8;
  localparam int SYNC_LAT   = 2;
  localparam int WATCHDOG   = 200000;

  logic clk;
  logic rst_n;
  logic sel;
  logic bit_clk;
  logic strb;
  logic strb_n;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string phase  = "R7";

  // Reference model state
  int hi_cnt  = 0;
  bit m_cap   = 0;
  bit m_start = 0;
  bit m_half  = 0;
  int m_per   = 0;
  bit m_strb  = 0;

  bitclk_gen i_bitclk_gen (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .blk_sel_i     (sel),
    .bit_clk_o     (bit_clk),
    .byte_strb_o   (strb),
    .byte_strb_n_o (strb_n)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // Falling-edge view of the select input
  always @(negedge clk) begin
    if (!rst_n) m_cap = 0;
    else if (hi_cnt >= SYNC_LAT) m_cap = sel;
  end

  // Behavioural reference, advanced on each rising edge or async reset
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt = 0; m_cap = 0; m_start = 0; m_half = 0; m_per = 0; m_strb = 0;
    end else if (hi_cnt < SYNC_LAT) begin
      hi_cnt++;
    end else if (m_start || m_cap) begin
      m_start = 1;
      m_half  = !m_half;
      if (m_half) begin
        m_per++;
        m_strb = (m_per % BYTE_LEN) == 0;
      end
    end
  end

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare with the model on every cycle, away from the edge
  always @(posedge clk) begin
    #3;
    if (!done) begin
      check_bit(phase, "bit_clk", bit_clk, m_half);
      check_bit("R5", "byte_strb", strb, m_strb);
      check_bit("R6", "byte_strb_n", strb_n, !m_strb);
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    sel   = 1'b0;
    phase = "R7";
    cycles(3);
    // R7 reset values
    check_bit("R7", "reset bit_clk", bit_clk, 1'b0);
    check_bit("R7", "reset byte_strb", strb, 1'b0);
    check_bit("R6", "reset byte_strb_n", strb_n, 1'b1);

    phase = "R2";
    rst_n = 1'b1;
    cycles(12);
    check_bit("R2", "idle bit_clk", bit_clk, 1'b0);

    // R3: pulse between falling and rising edge must be missed
    phase = "R3";
    @(posedge clk); #6; sel = 1'b1; #3; sel = 1'b0;
    cycles(6);
    check_bit("R3", "missed pulse", bit_clk, 1'b0);

    // R3: pulse covering only a falling edge must start the clock
    @(posedge clk); #2; sel = 1'b1; #6; sel = 1'b0;
    @(posedge clk); #3;
    check_bit("R3", "start high", bit_clk, 1'b1);
    phase = "R1";
    cycles(20);

    // R4: select activity after start is ignored
    phase = "R4";
    for (int i = 0; i < 40; i++) begin
      sel = ((i % 3) == 0) || ((i % 7) == 2);
      cycles(1);
    end
    sel = 1'b0;
    cycles(30);

    // R7 / R8: reset mid-byte with select already high
    phase = "R7";
    cycles(3);
    rst_n = 1'b0;
    #1;
    check_bit("R7", "async bit_clk", bit_clk, 1'b0);
    check_bit("R7", "async byte_strb_n", strb_n, 1'b1);
    sel = 1'b1;
    cycles(2);
    rst_n = 1'b1;
    phase = "R8";
    cycles(50);

    // R8: second restart after an idle stretch
    phase = "R7";
    rst_n = 1'b0;
    sel   = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    phase = "R2";
    cycles(10);
    phase = "R8";
    sel = 1'b1;
    cycles(45);
    sel = 1'b0;
    phase = "R1";
    cycles(20);
    finish_run();
  end

endmodule